// File: doc/BRIEF.md
# Command Ring Consumer

This block drains a command ring held in memory. While the ring is enabled, holds entries, and no command error is waiting for acknowledgement, it fetches the entry at the consumer slot as one 16-byte read. It decodes the opcode in the low byte of the first word and handles the command. The consumer pointer moves forward only after the command has been handled. Every recognised opcode except the sync opcode is accepted as a no-op. A sync whose completion-signal field requests it raises a one-cycle sync interrupt.

An opcode outside the recognised set, or a read that returns an error, stops consumption. The pointer is left on the failing entry. A code is written into the error field of the consumer register, and the command-error bit of the global error flag is toggled. A one-cycle global-error interrupt is raised. Consumption resumes only once software makes its acknowledge bit equal to the flag again. The ring pointer carries one wrap bit above the slot index, so a full ring can be told apart from an empty one.

Top module: `cq_consumer`

## Requirements
- R1: After reset the consumer register reads zero, no read is requested, both interrupts are low and the command-error flag is 0.
- R2: A read is requested only when the enable input is high, the consumer pointer (slot index plus wrap bit) differs from the producer pointer, and no error is pending. Only one read is outstanding at a time. The read address is the base address plus 16 times the slot index.
- R3: Opcodes 0x01 to 0x07, 0x10 to 0x13, 0x18, 0x1A, 0x20 to 0x23, 0x28, 0x2A, 0x30, 0x40, 0x41, 0x44 and 0x45 are no-ops. Each one moves the consumer pointer forward by one in the cycle after its read response.
- R4: Opcode 0x46 is sync. Its completion-signal field is bits [13:12] of the first word. When bit 12 of that word is set, a one-cycle sync interrupt is raised in the same cycle that the pointer advances. When bit 12 is clear, no interrupt is raised, whatever the value of bit 13.
- R5: Any other opcode writes error code 1 into bits [30:24] of the consumer register and leaves the pointer unchanged. It toggles the command-error flag and raises a one-cycle global-error interrupt.
- R6: A read response that carries an error writes error code 2 into the error field. Pointer, flag and interrupt behave as in R5.
- R7: While the command-error flag differs from the acknowledge input, no read is issued. Consumption resumes once the two are equal again.
- R8: The consumer pointer occupies bits [LOG2_DEPTH:0] of the consumer register. Slot index LOG2_DEPTH bits wide, wrap bit above it. Advancing past the last slot returns the index to 0 and flips the wrap bit. Equal indices with different wrap bits mean the ring is full, and the full ring is drained.
- R9: A command whose read was issued before the enable input fell still completes. After that, no further read is issued while the enable stays low.
- R10: The error field keeps its last code through later successful commands, until another error overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_enable | input | 1 | Ring consumption enable |
| prod_ptr | input | LOG2_DEPTH+1 | Producer pointer: slot index plus wrap bit |
| gerr_ack | input | 1 | Software acknowledge of the command-error flag |
| base_addr | input | ADDR_W | Byte address of ring slot 0 |
| rd_req | output | 1 | One-cycle read request strobe |
| rd_addr | output | ADDR_W | Byte address of the requested entry |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_err | input | 1 | Read response carries an error |
| rd_rsp_data | input | CMD_W | Returned command, first word in the low 32 bits |
| cons_reg | output | 32 | Consumer pointer in [LOG2_DEPTH:0], error code in [30:24] |
| gerr_cmd | output | 1 | Command-error flag of the global error register |
| sync_irq | output | 1 | One-cycle sync completion interrupt |
| gerr_irq | output | 1 | One-cycle global-error interrupt |

## Verification
The assertions assume that the memory returns exactly one response for each request, and never before the request has been seen. They also assume that the acknowledge input changes only while an error is pending or being cleared. The bench memory holds the address of a single request and answers it once, after a latency of zero to six cycles. The scenario changes the acknowledge only after an error has been observed, and rewrites ring entries only while the consumer is stalled or the producer pointer has not yet reached them.

// File: rtl/cq_pkg.sv
`timescale 1ns/1ps
package cq_pkg;

    typedef enum logic [0:0] {
        CQ_IDLE = 1'b0,
        CQ_WAIT = 1'b1
    } cq_state_e;

    localparam logic [6:0] CQ_ERR_NONE    = 7'd0;
    localparam logic [6:0] CQ_ERR_ILLEGAL = 7'd1;
    localparam logic [6:0] CQ_ERR_ABORT   = 7'd2;

    localparam logic [7:0] CQ_OP_SYNC     = 8'h46;
    localparam int         CQ_ENTRY_LOG2  = 4;
    localparam int         CQ_ERR_LSB     = 24;

    function automatic logic cq_op_known(input logic [7:0] op);
        logic known;
        case (op)
            8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
            8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
            8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A, 8'h30,
            8'h40, 8'h41, 8'h44, 8'h45, 8'h46: known = 1'b1;
            default:                           known = 1'b0;
        endcase
        return known;
    endfunction

endpackage

// File: rtl/cq_opcode_decode.sv
`timescale 1ns/1ps
module cq_opcode_decode (
    input  logic [13:0] word0_lo,
    output logic        op_known,
    output logic        op_sync,
    output logic        sync_signal
);
    import cq_pkg::*;

    logic [7:0] opcode;
    logic [1:0] cs_field;

    always_comb begin
        opcode      = word0_lo[7:0];
        cs_field    = word0_lo[13:12];
        op_known    = cq_op_known(opcode);
        op_sync     = (opcode == CQ_OP_SYNC);
        sync_signal = op_sync && cs_field[0];
    end
endmodule

// File: rtl/cq_ring_ptr.sv
`timescale 1ns/1ps
module cq_ring_ptr #(
    parameter int LOG2_DEPTH = 3,
    parameter int ADDR_W     = 32
) (
    input  logic [LOG2_DEPTH:0]   cons_ptr,
    input  logic [LOG2_DEPTH:0]   prod_ptr,
    input  logic [ADDR_W-1:0]     base_addr,
    output logic [LOG2_DEPTH:0]   cons_ptr_next,
    output logic                  ring_empty,
    output logic [ADDR_W-1:0]     entry_addr
);
    import cq_pkg::*;

    localparam int PTR_W = LOG2_DEPTH + 1;

    logic [LOG2_DEPTH-1:0] slot;
    logic [ADDR_W-1:0]     slot_offset;

    always_comb begin
        // Incrementing the full pointer carries into the wrap bit.
        cons_ptr_next = cons_ptr + PTR_W'(1);
        ring_empty    = (cons_ptr == prod_ptr);
        slot          = cons_ptr[LOG2_DEPTH-1:0];
        slot_offset   = ADDR_W'(slot) << CQ_ENTRY_LOG2;
        entry_addr    = base_addr + slot_offset;
    end
endmodule

// File: rtl/cq_consumer.sv
`timescale 1ns/1ps
module cq_consumer #(
    parameter int LOG2_DEPTH = 3,
    parameter int ADDR_W     = 32,
    parameter int CMD_W      = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  q_enable,
    input  logic [LOG2_DEPTH:0]   prod_ptr,
    input  logic                  gerr_ack,
    input  logic [ADDR_W-1:0]     base_addr,
    output logic                  rd_req,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_rsp_valid,
    input  logic                  rd_rsp_err,
    input  logic [CMD_W-1:0]      rd_rsp_data,
    output logic [31:0]           cons_reg,
    output logic                  gerr_cmd,
    output logic                  sync_irq,
    output logic                  gerr_irq
);
    import cq_pkg::*;

    localparam int PTR_W = LOG2_DEPTH + 1;

    typedef struct packed {
        cq_state_e          state;
        logic [PTR_W-1:0]   cons;
        logic [6:0]         err;
        logic               gerr;
        logic               req;
        logic [ADDR_W-1:0]  addr;
        logic               sync_irq;
        logic               gerr_irq;
    } cq_regs_t;

    cq_regs_t regs_d, regs_q;

    logic [PTR_W-1:0]  cons_next;
    logic              ring_empty;
    logic [ADDR_W-1:0] entry_addr;
    logic              op_known, op_sync, sync_signal;
    logic              err_pending;
    logic              rsp_data_unused;

    assign rsp_data_unused = ^rd_rsp_data[CMD_W-1:14];

    cq_ring_ptr #(
        .LOG2_DEPTH (LOG2_DEPTH),
        .ADDR_W     (ADDR_W)
    ) u_ptr (
        .cons_ptr      (regs_q.cons),
        .prod_ptr      (prod_ptr),
        .base_addr     (base_addr),
        .cons_ptr_next (cons_next),
        .ring_empty    (ring_empty),
        .entry_addr    (entry_addr)
    );

    cq_opcode_decode u_dec (
        .word0_lo    (rd_rsp_data[13:0]),
        .op_known    (op_known),
        .op_sync     (op_sync),
        .sync_signal (sync_signal)
    );

    assign err_pending = regs_q.gerr ^ gerr_ack;

    always_comb begin
        regs_d          = regs_q;
        regs_d.req      = 1'b0;
        regs_d.sync_irq = 1'b0;
        regs_d.gerr_irq = 1'b0;
        case (regs_q.state)
            CQ_IDLE: begin
                if (q_enable && !ring_empty && !err_pending) begin
                    regs_d.req   = 1'b1;
                    regs_d.addr  = entry_addr;
                    regs_d.state = CQ_WAIT;
                end
            end
            CQ_WAIT: begin
                if (rd_rsp_valid) begin
                    regs_d.state = CQ_IDLE;
                    if (rd_rsp_err || !op_known) begin
                        regs_d.err      = rd_rsp_err ? CQ_ERR_ABORT : CQ_ERR_ILLEGAL;
                        regs_d.gerr     = ~regs_q.gerr;
                        regs_d.gerr_irq = 1'b1;
                    end else begin
                        regs_d.cons     = cons_next;
                        regs_d.sync_irq = op_sync && sync_signal;
                    end
                end
            end
            default: regs_d.state = CQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{state: CQ_IDLE, err: CQ_ERR_NONE, default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        cons_reg                          = '0;
        cons_reg[PTR_W-1:0]               = regs_q.cons;
        cons_reg[CQ_ERR_LSB+6:CQ_ERR_LSB] = regs_q.err;
    end

    assign rd_req   = regs_q.req;
    assign rd_addr  = regs_q.addr;
    assign gerr_cmd = regs_q.gerr;
    assign sync_irq = regs_q.sync_irq;
    assign gerr_irq = regs_q.gerr_irq;

endmodule

// File: rtl/cq_consumer_chk.sv
`timescale 1ns/1ps
module cq_consumer_chk #(
    parameter int LOG2_DEPTH = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                q_enable,
    input logic [LOG2_DEPTH:0] prod_ptr,
    input logic                gerr_ack,
    input logic                rd_req,
    input logic                rd_rsp_valid,
    input logic [31:0]         cons_reg,
    input logic                gerr_cmd,
    input logic                sync_irq,
    input logic                gerr_irq
);
    localparam int PTR_W = LOG2_DEPTH + 1;

    logic [PTR_W-1:0] cons_ptr;
    logic [6:0]       err_code;
    logic             cons_unused;

    assign cons_ptr    = cons_reg[PTR_W-1:0];
    assign err_code    = cons_reg[30:24];
    assign cons_unused = ^{cons_reg[31], cons_reg[23:PTR_W]};

    AST_FETCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> $past(q_enable && (gerr_cmd == gerr_ack) && (cons_ptr != prod_ptr))); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R2
    AST_ADVANCE_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_ptr != $past(cons_ptr)) |-> $past(rd_rsp_valid)); // R3
    AST_SYNC_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sync_irq |-> (cons_ptr != $past(cons_ptr))); // R4
    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_irq && gerr_irq)); // R4
    AST_ERR_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        gerr_irq |-> (cons_ptr == $past(cons_ptr))); // R5
    AST_ERR_TOGGLES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        gerr_irq |-> (gerr_cmd != $past(gerr_cmd))); // R5
    AST_ERR_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        gerr_irq |-> (err_code == 7'd1 || err_code == 7'd2)); // R6
    AST_PTR_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_ptr != $past(cons_ptr)) |-> (cons_ptr == PTR_W'($past(cons_ptr) + 1'b1))); // R8
    AST_CODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !gerr_irq |-> (err_code == $past(err_code))); // R10
endmodule

bind cq_consumer cq_consumer_chk #(.LOG2_DEPTH(LOG2_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .q_enable     (q_enable),
    .prod_ptr     (prod_ptr),
    .gerr_ack     (gerr_ack),
    .rd_req       (rd_req),
    .rd_rsp_valid (rd_rsp_valid),
    .cons_reg     (cons_reg),
    .gerr_cmd     (gerr_cmd),
    .sync_irq     (sync_irq),
    .gerr_irq     (gerr_irq)
);

// File: tb/tb_cq_consumer.sv
`timescale 1ns/1ps
module tb_cq_consumer;
    localparam int L     = 3;
    localparam int PW    = L + 1;
    localparam int AW    = 32;
    localparam int CW    = 128;
    localparam int DEPTH = 8;
    localparam logic [AW-1:0] BASE = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          q_enable = 1'b0;
    logic [PW-1:0] prod_ptr = '0;
    logic          gerr_ack = 1'b0;
    logic [AW-1:0] base_addr = BASE;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_rsp_valid = 1'b0;
    logic          rd_rsp_err = 1'b0;
    logic [CW-1:0] rd_rsp_data = '0;
    logic [31:0]   cons_reg;
    logic          gerr_cmd, sync_irq, gerr_irq;

    always #2.5 clk = ~clk;

    cq_consumer #(.LOG2_DEPTH(L), .ADDR_W(AW), .CMD_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .prod_ptr(prod_ptr),
        .gerr_ack(gerr_ack), .base_addr(base_addr), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_err(rd_rsp_err),
        .rd_rsp_data(rd_rsp_data), .cons_reg(cons_reg), .gerr_cmd(gerr_cmd),
        .sync_irq(sync_irq), .gerr_irq(gerr_irq)
    );

    int checks = 0;
    int failures = 0;
    int n_req = 0, n_sync = 0, n_gerr = 0;
    int cycles = 0;
    bit done = 0;

    logic [CW-1:0] mem [DEPTH];
    logic [DEPTH-1:0] abort_mask = '0;
    int lat = 1;
    bit pend = 0;
    int cd = 0;
    logic [AW-1:0] paddr = '0;

    int legal_ops [25] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                           8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
                           8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A, 8'h30,
                           8'h40, 8'h41, 8'h44, 8'h45, 8'h46};

    function automatic bit is_legal(input int op);
        foreach (legal_ops[i]) if (legal_ops[i] == op) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference model, updated on every rising edge from the inputs.
    int m_cons = 0, m_err = 0, m_gerr = 0, m_req = 0, m_sync = 0, m_girq = 0;
    bit m_busy = 0;
    logic [AW-1:0] m_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cons = 0; m_err = 0; m_gerr = 0; m_req = 0; m_sync = 0; m_girq = 0;
            m_busy = 0; m_addr = '0;
        end else begin
            m_req = 0; m_sync = 0; m_girq = 0;
            if (!m_busy) begin
                if (q_enable && m_cons != int'(prod_ptr) && m_gerr == int'(gerr_ack)) begin
                    m_req  = 1;
                    m_addr = BASE + AW'(16 * (m_cons % DEPTH));
                    m_busy = 1;
                end
            end else if (rd_rsp_valid) begin
                m_busy = 0;
                if (rd_rsp_err) begin
                    m_err = 2; m_gerr = 1 - m_gerr; m_girq = 1;
                end else if (!is_legal(int'(rd_rsp_data[7:0]))) begin
                    m_err = 1; m_gerr = 1 - m_gerr; m_girq = 1;
                end else begin
                    m_cons = (m_cons + 1) % (2 * DEPTH);
                    if (rd_rsp_data[7:0] == 8'h46 && rd_rsp_data[12]) m_sync = 1;
                end
            end
        end
    end

    // Per-cycle comparison and memory responder, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 consumer pointer", 32'(cons_reg[PW-1:0]), 32'(m_cons));
            chk("R10 error field", 32'(cons_reg[30:24]), 32'(m_err));
            chk("R2 read strobe", 32'(rd_req), 32'(m_req));
            if (m_req != 0) chk("R2 read address", rd_addr, m_addr);
            chk("R4 sync interrupt", 32'(sync_irq), 32'(m_sync));
            chk("R5 global-error interrupt", 32'(gerr_irq), 32'(m_girq));
            chk("R7 command-error flag", 32'(gerr_cmd), 32'(m_gerr));
            if (rd_req) n_req++;
            if (sync_irq) n_sync++;
            if (gerr_irq) n_gerr++;

            rd_rsp_valid <= 1'b0;
            if (rd_req) begin pend = 1; paddr = rd_addr; cd = lat; end
            if (pend) begin
                if (cd == 0) begin
                    rd_rsp_valid <= 1'b1;
                    rd_rsp_err   <= abort_mask[(paddr - BASE) >> 4];
                    rd_rsp_data  <= mem[(paddr - BASE) >> 4];
                    pend = 0;
                end else cd--;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic logic [CW-1:0] cmd(input logic [31:0] w0);
        return {96'hDEAD_BEEF_0123_4567_89AB_CDEF, w0};
    endfunction

    initial begin
        foreach (mem[i]) mem[i] = cmd(32'h0000_0001);
        step(4);
        // R1: reset state
        chk("R1 consumer register at reset", cons_reg, 32'h0);
        chk("R1 read strobe at reset", 32'(rd_req), 32'h0);
        chk("R1 interrupts at reset", 32'({sync_irq, gerr_irq, gerr_cmd}), 32'h0);
        rst_n = 1'b1;
        step(2);

        // R2: enabled but empty ring issues no read
        q_enable = 1'b1;
        n_req = 0;
        step(10);
        chk("R2 no read on empty ring", 32'(n_req), 32'd0);

        // R3/R4: no-op commands and sync variants
        mem[0] = cmd(32'h0000_0001);
        mem[1] = cmd(32'h0000_002A);
        mem[2] = cmd(32'h0000_1046);
        mem[3] = cmd(32'h0000_2046);
        n_sync = 0; lat = 0;
        prod_ptr = 4'd4;
        step(30);
        chk("R3 pointer after four commands", 32'(cons_reg[PW-1:0]), 32'd4);
        chk("R4 only bit 12 requests sync interrupt", 32'(n_sync), 32'd1);

        // R5: illegal opcode
        mem[4] = cmd(32'h0000_0008);
        n_gerr = 0; lat = 2;
        prod_ptr = 4'd5;
        step(20);
        chk("R5 pointer held on illegal", 32'(cons_reg[PW-1:0]), 32'd4);
        chk("R5 illegal error code", 32'(cons_reg[30:24]), 32'd1);
        chk("R5 flag toggled", 32'(gerr_cmd), 32'd1);
        chk("R5 one global-error interrupt", 32'(n_gerr), 32'd1);
        n_req = 0;
        step(15);
        chk("R7 no read while error pending", 32'(n_req), 32'd0);

        // R7: acknowledge resumes; R10 code kept through success
        mem[4] = cmd(32'h0000_0010);
        gerr_ack = 1'b1;
        step(20);
        chk("R7 resumed after acknowledge", 32'(cons_reg[PW-1:0]), 32'd5);
        chk("R10 code kept after success", 32'(cons_reg[30:24]), 32'd1);

        // R6: read abort
        abort_mask[5] = 1'b1;
        n_gerr = 0;
        prod_ptr = 4'd6;
        step(20);
        chk("R6 pointer held on abort", 32'(cons_reg[PW-1:0]), 32'd5);
        chk("R6 abort error code", 32'(cons_reg[30:24]), 32'd2);
        chk("R6 flag toggled back", 32'(gerr_cmd), 32'd0);
        chk("R6 one global-error interrupt", 32'(n_gerr), 32'd1);
        abort_mask[5] = 1'b0;
        gerr_ack = 1'b0;
        step(20);
        chk("R6 recovered pointer", 32'(cons_reg[PW-1:0]), 32'd6);

        // R8: wrap past last slot
        mem[6] = cmd(32'h0000_0007);
        mem[7] = cmd(32'h0000_0045);
        mem[0] = cmd(32'h0000_0013);
        mem[1] = cmd(32'h0000_0030);
        lat = 1;
        prod_ptr = 4'd10;
        step(40);
        chk("R8 wrapped pointer", 32'(cons_reg[PW-1:0]), 32'd10);

        // R9: enable drops with a read in flight
        mem[2] = cmd(32'h0000_0040);
        mem[3] = cmd(32'h0000_0041);
        lat = 6;
        prod_ptr = 4'd12;
        while (!rd_req) step(1);
        q_enable = 1'b0;
        n_req = 0;
        step(25);
        chk("R9 in-flight command completes", 32'(cons_reg[PW-1:0]), 32'd11);
        chk("R9 no read while disabled", 32'(n_req), 32'd0);
        q_enable = 1'b1;
        lat = 1;
        step(20);
        chk("R9 resumes on enable", 32'(cons_reg[PW-1:0]), 32'd12);

        // R8: full ring (equal index, different wrap) is drained
        foreach (mem[i]) mem[i] = cmd(32'h0000_0018 + 32'(i % 2) * 2);
        mem[6] = cmd(32'h0000_3046);
        n_req = 0; n_sync = 0;
        prod_ptr = 4'd4;
        step(80);
        chk("R8 full ring drained", 32'(cons_reg[PW-1:0]), 32'd4);
        chk("R8 eight reads for full ring", 32'(n_req), 32'd8);
        chk("R4 sync with both field bits", 32'(n_sync), 32'd1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule